// File: doc/BRIEF.md
# Two-Wire Indexed Configuration Register Target

This block is the serial target side of a clock generator's control path. An SMBus host reaches a small file of eight-bit configuration registers through it. The command byte picks the access style. With its top bit set, the command names one register offset, and that access moves one byte or a low/high byte pair. With the command equal to zero, the access covers the whole file starting at offset zero, and a byte count travels ahead of the data in both directions.

The target watches the SCL and SDA lines after a synchronizer. It pulls SDA low through an open-drain enable to acknowledge bytes and to send read data. Every register is also exposed as a flat vector for the frequency and watchdog logic. A one-cycle strobe marks each register that a write changes. A pulse marks the stop condition that closes any transaction addressed to this target. Two bytes are read-only: one holds the frequency straps sampled after reset, and the other holds an identification code. A watchdog status bit is set by hardware and cleared when software writes a 1 to it.

Top module: `smbreg_target`

## Requirements
- R1: A transaction whose 7-bit address differs from parameter DEV_ADDR (default 0x69) gets no acknowledge. SDA stays released for the whole transaction, no register changes, and no end pulse is emitted.
- R2: A command with bit 7 = 1 selects indexed access at the offset in bits 6:0. A one-byte write stores the byte there, and a one-byte read (repeated start, read address) returns it.
- R3: In an indexed access of two bytes, the first byte goes to or comes from the commanded offset and the second to or from the next offset, for both writes and reads.
- R4: Command 0x00 is a block write. The byte after it is a count, and the data bytes that follow land at offsets 0, 1, 2, … in order. A stop after any complete byte leaves all higher offsets unchanged.
- R5: Command 0x00 followed by a repeated start and a read address is a block read. The first byte sent is the number of registers (18), then offsets 0, 1, … follow. A master NACK ends the transfer and SDA is released.
- R6: A command with bit 7 = 0 and nonzero bits 6:0, or with bit 7 = 1 and an offset of 18 or more, is not acknowledged, and no register changes.
- R7: Offset 1 reads {strap[4:0], 3'b000}, with the straps sampled in the first clock after reset and fixed afterwards. Offset 6 reads {REV_ID[3:0], 4'b1000}. Writes to either offset are acknowledged and ignored, and they raise no strobe.
- R8: The reset values are: offsets 2 and 4 = 0xFF, 3 = 0xF3, 5 = 0x1F, 7 = 0x7E, 8 = 0x3E, 15 = 0x03, and every other writable offset = 0x00.
- R9: Reserved bits ignore writes and keep their reset value. The writable masks are 0xFF for offsets 0, 2, 4, 8, 10–14, 0xF3 for 3, 0x1F for 5, 0x7E for 7, 0xFA for 9, and 0x00 for 15–17.
- R10: Bit 2 of offset 9 is set by a tmo_set_i pulse. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R11: Each accepted write to an offset with writable bits gives exactly one one-cycle pulse on that offset's wr_stb_o bit, and at most one strobe bit is high at a time. xfer_end_o pulses for one cycle at the stop of each transaction that matched the address.
- R12: In a block write, data bytes beyond the count are not acknowledged and are not stored.
- R13: The target changes its SDA drive only while SCL is low, and it has released SDA after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 5 | Frequency strap pins, sampled once after reset |
| tmo_set_i | input | 1 | Watchdog timeout pulse, sets the status bit |
| regs_o | output | NUM_REGS*8 | All registers, offset n at bits 8n+7:8n |
| wr_stb_o | output | NUM_REGS | One-cycle pulse per register written |
| xfer_end_o | output | 1 | One-cycle pulse at the stop of an addressed transaction |

## Verification
A table of single-byte writes, each followed by a read of the same offset, covers fully writable, partly reserved, fully reserved and read-only offsets. For each entry the bench compares the read value, the port value and the strobe count, which separates a mask error from a strobe error. Directed transactions then cover word, block-write, block-read and over-count block writes, where the order of the returned bytes shows an indexing slip or a missing count byte. Wrong addresses, illegal commands, strap changes after reset, and the set and clear of the status bit each isolate one rule: a cost-free ignore must leave both SDA and the registers untouched.

// File: rtl/smbreg_pkg.sv
`timescale 1ns/1ps
package smbreg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_WDATA, ST_RDATA, ST_MACK, ST_SKIP
   } smb_state_e;

   typedef enum logic [1:0] {RK_RW, RK_STRAP, RK_ID, RK_STAT} reg_kind_e;

   localparam int STRAP_IDX = 1;
   localparam int ID_IDX    = 6;
   localparam int STAT_IDX  = 9;
   localparam int STAT_BIT  = 2;
   localparam int STRAP_W   = 5;
   localparam logic [3:0] VENDOR_CODE = 4'b1000;

   function automatic reg_kind_e reg_kind(input int idx);
      case (idx)
         STRAP_IDX: return RK_STRAP;
         ID_IDX:    return RK_ID;
         STAT_IDX:  return RK_STAT;
         default:   return RK_RW;
      endcase
   endfunction

   function automatic logic [7:0] reg_rst(input int idx);
      case (idx)
         2, 4:    return 8'hFF;
         3:       return 8'hF3;
         5:       return 8'h1F;
         7:       return 8'h7E;
         8:       return 8'h3E;
         15:      return 8'h03;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] reg_wmask(input int idx);
      case (idx)
         1, 6, 15, 16, 17: return 8'h00;
         3:       return 8'hF3;
         5:       return 8'h1F;
         7:       return 8'h7E;
         9:       return 8'hFA;
         default: return 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/smbreg_line_sync.sv
`timescale 1ns/1ps
module smbreg_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_p, sda_p;
   logic scl_d, sda_d;

   generate
      if (STAGES < 2) begin : g_bad
         $error("smbreg_line_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= '1;
         sda_p <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_p <= {scl_p[STAGES-2:0], scl_i};
         sda_p <= {sda_p[STAGES-2:0], sda_i};
         scl_d <= scl_p[STAGES-1];
         sda_d <= sda_p[STAGES-1];
      end
   end

   assign scl_s     = scl_p[STAGES-1];
   assign sda_s     = sda_p[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbreg_xfer_fsm.sv
`timescale 1ns/1ps
module smbreg_xfer_fsm
   import smbreg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int         NUM_REGS = 18
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic       sda_s,
   input  logic [7:0] rd_data,
   output logic [7:0] rd_idx,
   output logic       wr_en,
   output logic [7:0] wr_idx,
   output logic [7:0] wr_data,
   output logic       sda_oe,
   output logic       xfer_end
);
   localparam logic [7:0] NREG_B = 8'(NUM_REGS);

   smb_state_e state;
   logic [3:0] bitcnt;
   logic [7:0] sh;
   logic [7:0] idx;
   logic [7:0] remain;
   logic       ack_ph, blk, addressed, cnt_pending, mack_ok;
   logic [7:0] tx_byte;

   assign tx_byte = cnt_pending ? NREG_B : rd_data;
   assign rd_idx  = idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         bitcnt      <= '0;
         sh          <= '0;
         idx         <= '0;
         remain      <= '0;
         ack_ph      <= 1'b0;
         blk         <= 1'b0;
         addressed   <= 1'b0;
         cnt_pending <= 1'b0;
         mack_ok     <= 1'b0;
         sda_oe      <= 1'b0;
         xfer_end    <= 1'b0;
         wr_en       <= 1'b0;
         wr_idx      <= '0;
         wr_data     <= '0;
      end else begin
         wr_en    <= 1'b0;
         xfer_end <= 1'b0;
         if (stop_det) begin
            state     <= ST_IDLE;
            sda_oe    <= 1'b0;
            ack_ph    <= 1'b0;
            bitcnt    <= '0;
            xfer_end  <= addressed;
            addressed <= 1'b0;
         end else if (start_det) begin
            state  <= ST_ADDR;
            sda_oe <= 1'b0;
            ack_ph <= 1'b0;
            bitcnt <= '0;
         end else if (scl_rise) begin
            if (!ack_ph) begin
               case (state)
                  ST_ADDR, ST_CMD, ST_CNT, ST_WDATA: begin
                     sh <= {sh[6:0], sda_s};
                     if (bitcnt != 4'd15) bitcnt <= bitcnt + 4'd1;
                  end
                  ST_RDATA: bitcnt <= bitcnt + 4'd1;
                  ST_MACK:  mack_ok <= ~sda_s;
                  default: ;
               endcase
            end
         end else if (scl_fall) begin
            if (ack_ph) begin
               ack_ph <= 1'b0;
               if (state == ST_RDATA) begin
                  sh     <= tx_byte;
                  sda_oe <= ~tx_byte[7];
                  bitcnt <= '0;
                  if (cnt_pending) cnt_pending <= 1'b0;
                  else if (idx != 8'hFF) idx <= idx + 8'd1;
               end else begin
                  sda_oe <= 1'b0;
               end
            end else begin
               case (state)
                  ST_ADDR: if (bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     if (sh[7:1] == DEV_ADDR) begin
                        addressed   <= 1'b1;
                        ack_ph      <= 1'b1;
                        sda_oe      <= 1'b1;
                        cnt_pending <= sh[0] & blk;
                        state       <= sh[0] ? ST_RDATA : ST_CMD;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
                  ST_CMD: if (bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     if (sh[7] && ({1'b0, sh[6:0]} < NREG_B)) begin
                        blk    <= 1'b0;
                        idx    <= {1'b0, sh[6:0]};
                        ack_ph <= 1'b1;
                        sda_oe <= 1'b1;
                        state  <= ST_WDATA;
                     end else if (sh == 8'h00) begin
                        blk    <= 1'b1;
                        idx    <= '0;
                        ack_ph <= 1'b1;
                        sda_oe <= 1'b1;
                        state  <= ST_CNT;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
                  ST_CNT: if (bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     remain <= sh;
                     ack_ph <= 1'b1;
                     sda_oe <= 1'b1;
                     state  <= ST_WDATA;
                  end
                  ST_WDATA: if (bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     if ((idx < NREG_B) && (!blk || remain != 8'd0)) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= idx;
                        wr_data <= sh;
                        idx     <= idx + 8'd1;
                        if (blk) remain <= remain - 8'd1;
                        ack_ph  <= 1'b1;
                        sda_oe  <= 1'b1;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
                  ST_RDATA: begin
                     if (bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        state  <= ST_MACK;
                     end else if (bitcnt != 4'd0) begin
                        sda_oe <= ~sh[6];
                        sh     <= {sh[6:0], 1'b0};
                     end
                  end
                  ST_MACK: begin
                     if (mack_ok) begin
                        state  <= ST_RDATA;
                        sh     <= tx_byte;
                        sda_oe <= ~tx_byte[7];
                        bitcnt <= '0;
                        if (cnt_pending) cnt_pending <= 1'b0;
                        else if (idx != 8'hFF) idx <= idx + 8'd1;
                     end else begin
                        state  <= ST_SKIP;
                        sda_oe <= 1'b0;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/smbreg_regfile.sv
`timescale 1ns/1ps
module smbreg_regfile
   import smbreg_pkg::*;
#(
   parameter int         NUM_REGS = 18,
   parameter logic [3:0] REV_ID   = 4'h0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [7:0]            wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [7:0]            rd_idx,
   output logic [7:0]            rd_data,
   input  logic [STRAP_W-1:0]    strap_i,
   input  logic                  tmo_set_i,
   output logic [NUM_REGS*8-1:0] regs_o,
   output logic [NUM_REGS-1:0]   wr_stb_o
);
   localparam int IW = $clog2(NUM_REGS);

   logic [NUM_REGS-1:0][7:0] q;
   logic [STRAP_W-1:0]       strap_q;
   logic                     strap_taken;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_q     <= '0;
         strap_taken <= 1'b0;
      end else if (!strap_taken) begin
         strap_q     <= strap_i;
         strap_taken <= 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         localparam reg_kind_e  KIND = reg_kind(i);
         localparam logic [7:0] RV   = reg_rst(i);
         localparam logic [7:0] WM   = reg_wmask(i);
         logic hit;
         assign hit = wr_en && (wr_idx == 8'(i));

         if (KIND == RK_STRAP) begin : g_strap
            assign q[i]        = {strap_q, {(8-STRAP_W){1'b0}}};
            assign wr_stb_o[i] = 1'b0;
         end else if (KIND == RK_ID) begin : g_id
            assign q[i]        = {REV_ID, VENDOR_CODE};
            assign wr_stb_o[i] = 1'b0;
         end else if (KIND == RK_STAT) begin : g_stat
            logic [7:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  r <= RV;
               end else begin
                  if (hit) r <= (r & ~WM) | (wr_data & WM);
                  r[STAT_BIT] <= tmo_set_i | (r[STAT_BIT] & ~(hit & wr_data[STAT_BIT]));
               end
            end
            assign q[i]        = r;
            assign wr_stb_o[i] = hit;
         end else begin : g_rw
            logic [7:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   r <= RV;
               else if (hit) r <= (r & ~WM) | (wr_data & WM);
            end
            assign q[i]        = r;
            assign wr_stb_o[i] = hit && (WM != 8'h00);
         end
      end
   endgenerate

   assign regs_o  = q;
   assign rd_data = (rd_idx < 8'(NUM_REGS)) ? q[rd_idx[IW-1:0]] : 8'h00;
endmodule

// File: rtl/smbreg_target.sv
`timescale 1ns/1ps
module smbreg_target
   import smbreg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         NUM_REGS    = 18,
   parameter logic [3:0] REV_ID      = 4'h0,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   input  logic [4:0]            strap_i,
   input  logic                  tmo_set_i,
   output logic [NUM_REGS*8-1:0] regs_o,
   output logic [NUM_REGS-1:0]   wr_stb_o,
   output logic                  xfer_end_o
);
   generate
      if (NUM_REGS < STAT_IDX + 1 || NUM_REGS > 127) begin : g_bad_n
         $error("smbreg_target: NUM_REGS must lie in %0d..127", STAT_IDX + 1);
      end
      if (STRAP_W > 8) begin : g_bad_s
         $error("smbreg_target: strap field wider than a byte");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [7:0] rd_idx, rd_data, wr_idx, wr_data;
   logic wr_en;

   smbreg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   smbreg_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
      .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .sda_oe(sda_oe_o), .xfer_end(xfer_end_o)
   );

   smbreg_regfile #(.NUM_REGS(NUM_REGS), .REV_ID(REV_ID)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .strap_i(strap_i), .tmo_set_i(tmo_set_i), .regs_o(regs_o),
      .wr_stb_o(wr_stb_o)
   );
endmodule

// File: rtl/smbreg_target_chk.sv
`timescale 1ns/1ps
module smbreg_target_chk #(
   parameter int NUM_REGS = 18
) (
   input logic                clk,
   input logic                rst_n,
   input logic                scl_s,
   input logic                stop_det,
   input logic                sda_oe_o,
   input logic [NUM_REGS-1:0] wr_stb_o,
   input logic                xfer_end_o,
   input logic                tmo_set_i,
   input logic                stat_bit
);
   a_r11_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb_o));

   a_r11_end_single: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end_o |=> !xfer_end_o);

   a_r10_status_set: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_set_i |=> stat_bit);

   a_r13_release_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);

   a_r13_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !$past(scl_s));
endmodule

bind smbreg_target smbreg_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
   .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb_o), .xfer_end_o(xfer_end_o),
   .tmo_set_i(tmo_set_i),
   .stat_bit(regs_o[smbreg_pkg::STAT_IDX*8 + smbreg_pkg::STAT_BIT])
);

// File: tb/smbreg_target_bench.sv
`timescale 1ns/1ps
module smbreg_target_bench;
   localparam int         NREG = 18;
   localparam logic [6:0] DEV  = 7'h69;
   localparam int         Q    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_oe = 1'b0;
   logic dut_oe;
   logic sda;
   logic [4:0] strap = 5'b10110;
   logic tmo_set = 1'b0;
   logic [NREG*8-1:0] regs;
   logic [NREG-1:0] stb;
   logic xend;

   int n_chk = 0;
   int n_err = 0;
   int stb_cnt [NREG];
   int end_cnt = 0;
   logic dut_drove = 1'b0;
   logic [7:0] wbuf [16];
   logic [7:0] rbuf [16];
   logic ackv [20];

   always #10 clk = ~clk;
   assign sda = ~(m_oe | dut_oe);

   smbreg_target u_smbreg_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(dut_oe),
      .strap_i(strap), .tmo_set_i(tmo_set), .regs_o(regs), .wr_stb_o(stb),
      .xfer_end_o(xend)
   );

   initial for (int i = 0; i < NREG; i++) stb_cnt[i] = 0;
   always @(posedge clk) begin
      for (int i = 0; i < NREG; i++) if (stb[i]) stb_cnt[i] = stb_cnt[i] + 1;
      if (xend) end_cnt = end_cnt + 1;
      if (dut_oe) dut_drove = 1'b1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      m_oe = 1'b0; qw(); scl = 1'b1; qw(); m_oe = 1'b1; qw(); scl = 1'b0; qw();
   endtask

   task automatic bus_stop();
      m_oe = 1'b1; qw(); scl = 1'b1; qw(); m_oe = 1'b0; qw(); qw();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_oe = ~b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
      end
      m_oe = 1'b0; qw(); scl = 1'b1; qw(); ack = ~sda; qw(); scl = 1'b0; qw();
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic m_ack);
      m_oe = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         qw(); scl = 1'b1; qw(); b[i] = sda; qw(); scl = 1'b0;
      end
      qw(); m_oe = m_ack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
      m_oe = 1'b0;
   endtask

   task automatic bus_write(input logic [6:0] a, input logic [7:0] cmd, input int n);
      logic k;
      bus_start();
      send_byte({a, 1'b0}, k); ackv[0] = k;
      send_byte(cmd, k);       ackv[1] = k;
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], k); ackv[2+i] = k;
      end
      bus_stop();
   endtask

   task automatic bus_read(input logic [7:0] cmd, input int n);
      logic k;
      logic [7:0] b;
      bus_start();
      send_byte({DEV, 1'b0}, k); ackv[0] = k;
      send_byte(cmd, k);         ackv[1] = k;
      bus_start();
      send_byte({DEV, 1'b1}, k); ackv[2] = k;
      for (int i = 0; i < n; i++) begin
         recv_byte(b, (i != n - 1));
         rbuf[i] = b;
      end
      bus_stop();
   endtask

   function automatic logic [7:0] rst_exp(input int i);
      case (i)
         1: return 8'hB0;
         6: return 8'h08;
         2, 4: return 8'hFF;
         3: return 8'hF3;
         5: return 8'h1F;
         7: return 8'h7E;
         8: return 8'h3E;
         15: return 8'h03;
         default: return 8'h00;
      endcase
   endfunction

   // {offset, write data, expected value, expected strobe count}
   localparam logic [24:0] VEC [10] = '{
      {8'd0,  8'hA5, 8'hA5, 1'b1},
      {8'd3,  8'hFF, 8'hF3, 1'b1},
      {8'd5,  8'hFF, 8'h1F, 1'b1},
      {8'd7,  8'h81, 8'h00, 1'b1},
      {8'd2,  8'h3C, 8'h3C, 1'b1},
      {8'd15, 8'h00, 8'h03, 1'b0},
      {8'd17, 8'hFF, 8'h00, 1'b0},
      {8'd6,  8'hFF, 8'h08, 1'b0},
      {8'd1,  8'hFF, 8'hB0, 1'b0},
      {8'd14, 8'hC3, 8'hC3, 1'b1}
   };

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int e0, s0;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      qw();
      // R8 reset values at the port, plus R7 read-only bytes
      for (int i = 0; i < NREG; i++) chk("R8 reset value", regs[i*8 +: 8], rst_exp(i));
      chk("R13 idle release", dut_oe, 1'b0);
      chk("R11 no strobe at reset", stb, '0);

      // table of indexed write then read: R2, R7, R9, R11
      foreach (VEC[v]) begin
         logic [7:0] off, wd, ex;
         logic se;
         {off, wd, ex, se} = VEC[v];
         s0 = stb_cnt[off]; e0 = end_cnt;
         wbuf[0] = wd;
         bus_write(DEV, 8'h80 | off, 1);
         chk("R2 data ack", ackv[2], 1'b1);
         bus_read(8'h80 | off, 1);
         chk("R2/R9 read back", rbuf[0], ex);
         chk("R7/R9 port value", regs[off*8 +: 8], ex);
         chk("R11 strobe count", stb_cnt[off] - s0, se);
         chk("R11 end pulses", end_cnt - e0, 2);
      end

      // R3 word write and read
      wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      bus_write(DEV, 8'h8A, 2);
      chk("R3 low byte port", regs[10*8 +: 8], 8'h11);
      chk("R3 high byte port", regs[11*8 +: 8], 8'h22);
      bus_read(8'h8A, 2);
      chk("R3 low byte read", rbuf[0], 8'h11);
      chk("R3 high byte read", rbuf[1], 8'h22);

      // R4 block write, count 3, stop afterwards
      wbuf[0] = 8'd3; wbuf[1] = 8'h5A; wbuf[2] = 8'h6B; wbuf[3] = 8'h7C;
      bus_write(DEV, 8'h00, 4);
      chk("R4 count ack", ackv[2], 1'b1);
      chk("R4 offset0", regs[0 +: 8], 8'h5A);
      chk("R4 offset1 ro", regs[8 +: 8], 8'hB0);
      chk("R4 offset2", regs[16 +: 8], 8'h7C);
      chk("R4 offset3 untouched", regs[24 +: 8], 8'hF3);

      // R12 block write past the count
      wbuf[0] = 8'd1; wbuf[1] = 8'h11; wbuf[2] = 8'h22;
      bus_write(DEV, 8'h00, 3);
      chk("R12 in-count ack", ackv[3], 1'b1);
      chk("R12 excess nack", ackv[4], 1'b0);
      chk("R12 offset0", regs[0 +: 8], 8'h11);
      chk("R12 offset2 kept", regs[16 +: 8], 8'h7C);

      // R5 block read: count then offsets 0..
      bus_read(8'h00, 4);
      chk("R5 count byte", rbuf[0], NREG);
      chk("R5 byte0", rbuf[1], 8'h11);
      chk("R5 byte1", rbuf[2], 8'hB0);
      chk("R5 byte2", rbuf[3], 8'h7C);
      chk("R13 release after nack", dut_oe, 1'b0);

      // R1 foreign address
      e0 = end_cnt;
      dut_drove = 1'b0;
      wbuf[0] = 8'h99;
      bus_write(7'h2A, 8'h80, 1);
      chk("R1 address nack", ackv[0], 1'b0);
      chk("R1 sda never driven", dut_drove, 1'b0);
      chk("R1 offset0 kept", regs[0 +: 8], 8'h11);
      chk("R1 no end pulse", end_cnt - e0, 0);

      // R6 illegal commands
      wbuf[0] = 8'h55;
      bus_write(DEV, 8'h05, 1);
      chk("R6 block low bits nack", ackv[1], 1'b0);
      bus_write(DEV, 8'h80 | 8'd18, 1);
      chk("R6 offset range nack", ackv[1], 1'b0);
      chk("R6 offset0 kept", regs[0 +: 8], 8'h11);

      // R10 write-1-to-clear status
      @(posedge clk); #1 tmo_set = 1'b1;
      @(posedge clk); #1 tmo_set = 1'b0;
      qw();
      chk("R10 status set", regs[9*8 +: 8], 8'h04);
      wbuf[0] = 8'h00;
      bus_write(DEV, 8'h89, 1);
      bus_read(8'h89, 1);
      chk("R10 write 0 keeps", rbuf[0], 8'h04);
      wbuf[0] = 8'hFF;
      bus_write(DEV, 8'h89, 1);
      chk("R10 write 1 clears", regs[9*8 +: 8], 8'hFA);

      // R7 straps sampled only once after reset
      strap = 5'b00001;
      qw();
      bus_read(8'h81, 1);
      chk("R7 strap held", rbuf[0], 8'hB0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule